// File: doc/BRIEF.md
# Strap-addressed SMBus configuration target

This block is a small SMBus target for a clock fan-out chip. It runs entirely in the domain of a fast system clock that oversamples the bus. SCL and SDA each pass through a two-flop synchroniser. Edges, START and STOP are then found from the synchronised levels. SDA is driven open-drain: the block only ever pulls the line low.

The bus address is chosen by a three-level strap, which arrives already decoded into a two-bit code. The operating mode comes from a second three-level strap, decoded the same way. Both straps are captured on the first clock after reset is released and are held until the next reset. Behind the address sits a byte-wide register file with NREG entries. Byte 0 reports the captured mode. The low NOUT bits of register EN_REG drive the per-output enables used by the output stop logic.

Software reaches the registers with SMBus block write and block read transfers. The block stays silent whenever the reference-clock-present flag is low.

Top module: `smb_cfg_target`

## Requirements
- R1: The address strap selects the 7-bit address. Code 00 selects 0x6D (8-bit 0xDA/0xDB). Code 01 selects 0x6E (0xDC/0xDD). Code 10 or 11 selects 0x6C (0xD8/0xD9). A matching address byte is ACKed. Any other address is NACKed, and SDA stays released until the next START.
- R2: Both strap codes are captured on the first clock edge after reset release. Later changes on the strap pins have no effect until the next reset.
- R3: Byte 0 bit 3 reads 1 only for mode code 01, and byte 0 bit 1 reads 1 only for mode code 10 or 11. Mode code 00 reads both bits as 0.
- R4: Byte 0 bits 3 and 1 are read-only, and writes to them are dropped. The other bits of byte 0 are writable and reset to 0.
- R5: A block write is: address with R/W=0, a command byte, a count byte, then data bytes. The low log2(NREG) bits of the command select the first register. The target ACKs each byte and writes the data to consecutive registers, wrapping modulo NREG.
- R6: Data bytes beyond the count are NACKed and are not written. With a count of 0, the first data byte is already NACKed.
- R7: A block read is: address with W, a command byte, a repeated START, then address with R. The target returns a count byte equal to NREG, then registers starting at the command index, wrapping modulo NREG. It keeps sending while the host ACKs and releases SDA after a NACK.
- R8: out_en[i] equals bit i of register EN_REG (1 = output enabled). After reset that register is 0xFF, so all outputs are enabled.
- R9: While ref_ok is low, the bus is ignored: nothing is ACKed and no register changes. If ref_ok drops in the middle of a transfer, SDA is released on the next clock and the transfer is abandoned.
- R10: All registers other than byte 0 and EN_REG are plain read/write bytes that reset to 0.
- R11: The target starts pulling SDA low only at an edge where the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Decoded address strap: 00 low, 01 mid, 1x high |
| mode_sel | input | 2 | Decoded mode strap: 00 low, 01 mid, 1x high |
| ref_ok | input | 1 | Reference clock present |
| out_en | output | NOUT | Per-output enables |

## Verification
A pin change reaches the synchronised level two clocks later, and the block acts on it on the third. The ACK or the next transmit bit is therefore driven about three clocks after the host lowers SCL. The bench holds each SCL phase for six clocks and samples SDA three clocks into the high phase, after any change the target can make. SDA release after ref_ok falls is due on the very next clock and is covered by an assertion. The straps are changed three clocks after reset release, which is after the capture edge. out_en and register contents are compared only after STOP, well after the final write.

// File: rtl/smb_cfg_target.sv
module smb_cfg_target #(
  parameter int NREG   = 4,
  parameter int NOUT   = 4,
  parameter int EN_REG = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic [1:0]      addr_sel,
  input  logic [1:0]      mode_sel,
  input  logic            ref_ok,
  output logic [NOUT-1:0] out_en
);
  localparam int AW = $clog2(NREG);
  localparam logic [7:0] CNT_BYTE = 8'(NREG);
  localparam logic [7:0] B0_MASK = 8'hF5;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_CMD, P_CNT, P_DATA} ph_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d, scl_s, sda_s;
  logic       scl_rise, scl_fall, start_c, stop_c;

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  logic       latched;
  logic [6:0] my_addr;
  logic [1:0] mode_q;

  st_t        st;
  ph_t        ph;
  logic [7:0] sh, left;
  logic [3:0] bitn;
  logic       rnw, m_ack, drv;
  logic [AW-1:0] ptr;
  logic [7:0] regs [NREG];
  logic [7:0] rd_byte;

  assign rd_byte = (ptr == '0) ? {regs[0][7:4], mode_q[1], regs[0][2], mode_q[0], regs[0][0]}
                               : regs[ptr];
  assign sda_oe  = drv;
  assign out_en  = regs[EN_REG][NOUT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
      my_addr <= 7'h00;
      mode_q  <= 2'b00;
      st      <= S_IDLE;
      ph      <= P_ADDR;
      sh      <= 8'h00;
      left    <= 8'h00;
      bitn    <= 4'd0;
      rnw     <= 1'b0;
      m_ack   <= 1'b0;
      drv     <= 1'b0;
      ptr     <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= (i == EN_REG) ? 8'hFF : 8'h00;
    end else if (!latched) begin
      latched <= 1'b1;
      case (addr_sel)
        2'b00:   my_addr <= 7'h6D;
        2'b01:   my_addr <= 7'h6E;
        default: my_addr <= 7'h6C;
      endcase
      case (mode_sel)
        2'b00:   mode_q <= 2'b00;
        2'b01:   mode_q <= 2'b10;
        default: mode_q <= 2'b01;
      endcase
    end else if (!ref_ok) begin
      st  <= S_IDLE;
      drv <= 1'b0;
    end else if (start_c) begin
      st   <= S_RX;
      ph   <= P_ADDR;
      bitn <= 4'd0;
      drv  <= 1'b0;
    end else if (stop_c) begin
      st  <= S_IDLE;
      drv <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitn != 4'd8) begin
            sh   <= {sh[6:0], sda_s};
            bitn <= bitn + 4'd1;
          end else if (scl_fall && bitn == 4'd8) begin
            bitn <= 4'd0;
            case (ph)
              P_ADDR: begin
                if (sh[7:1] == my_addr) begin
                  drv <= 1'b1;
                  st  <= S_RACK;
                  rnw <= sh[0];
                  ph  <= sh[0] ? P_CNT : P_CMD;
                end else begin
                  st <= S_IDLE;
                end
              end
              P_CMD: begin
                drv <= 1'b1;
                st  <= S_RACK;
                rnw <= 1'b0;
                ptr <= sh[AW-1:0];
                ph  <= P_CNT;
              end
              P_CNT: begin
                drv  <= 1'b1;
                st   <= S_RACK;
                left <= sh;
                ph   <= P_DATA;
              end
              default: begin
                if (left != 8'h00) begin
                  drv       <= 1'b1;
                  st        <= S_RACK;
                  regs[ptr] <= (ptr == '0) ? (sh & B0_MASK) : sh;
                  ptr       <= ptr + 1'b1;
                  left      <= left - 8'h01;
                end else begin
                  st <= S_IDLE;
                end
              end
            endcase
          end
        end
        S_RACK: begin
          if (scl_fall) begin
            if (rnw) begin
              sh  <= CNT_BYTE;
              drv <= ~CNT_BYTE[7];
              st  <= S_TX;
            end else begin
              drv <= 1'b0;
              st  <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitn == 4'd7) begin
              drv  <= 1'b0;
              bitn <= 4'd0;
              st   <= S_TACK;
            end else begin
              sh   <= {sh[6:0], 1'b0};
              drv  <= ~sh[6];
              bitn <= bitn + 4'd1;
            end
          end
        end
        S_TACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              sh  <= rd_byte;
              drv <= ~rd_byte[7];
              ptr <= ptr + 1'b1;
              st  <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: drv <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk #(
  parameter int NOUT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ref_ok,
  input logic            sda_oe,
  input logic            scl_s,
  input logic            latched,
  input logic [6:0]      my_addr,
  input logic [1:0]      mode_q,
  input logic [NOUT-1:0] out_en
);
  assert_release_refoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok |=> !sda_oe);

  assert_en_frozen_refoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok |=> $stable(out_en));

  assert_strap_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && $past(latched)) |-> ($stable(my_addr) && $stable(mode_q)));

  assert_mode_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latched |-> $onehot0(mode_q));

  assert_pull_on_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));
endmodule

bind smb_cfg_target smb_cfg_target_chk #(.NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .sda_oe(sda_oe), .scl_s(scl_s),
  .latched(latched), .my_addr(my_addr), .mode_q(mode_q), .out_en(out_en)
);

// File: tb/smb_cfg_target_tb.sv
module smb_cfg_target_tb;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1, ref_ok = 1'b1;
  logic [1:0] a_sel = 2'b00, m_sel = 2'b00;
  logic       sda_oe;
  logic [3:0] out_en;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  smb_cfg_target #(.NREG(4), .NOUT(4), .EN_REG(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(a_sel), .mode_sel(m_sel), .ref_ok(ref_ok), .out_en(out_en)
  );

  int n_run = 0, n_bad = 0;
  logic [7:0] mdl  [4];
  logic [7:0] rdat [8];
  logic [7:0] wdat [8];

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] addr_of(input logic [1:0] s);
    return (s == 2'b00) ? 7'h6D : (s == 2'b01) ? 7'h6E : 7'h6C;
  endfunction

  function automatic logic [7:0] mode_bits(input logic [1:0] m);
    return (m == 2'b00) ? 8'h00 : (m == 2'b01) ? 8'h08 : 8'h02;
  endfunction

  function automatic logic [7:0] view(input int i);
    return (i == 0) ? (mdl[0] | mode_bits(m_sel_q)) : mdl[i];
  endfunction

  logic [1:0] m_sel_q = 2'b00;

  task automatic bus_start;
    sda_m = 1'b1; scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_rstart;
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(3); ack = ~sda_bus; wq(3); scl_m = 1'b0;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(3); b[i] = sda_bus; wq(3); scl_m = 1'b0;
    end
    sda_m = ~mack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
  endtask

  task automatic blk_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] cnt,
                           input int nd, output logic [15:0] acks);
    acks = '0;
    bus_start();
    put_byte({a, 1'b0}, acks[0]);
    if (acks[0]) begin
      put_byte(cmd, acks[1]);
      put_byte(cnt, acks[2]);
      for (int i = 0; i < nd; i++) put_byte(wdat[i], acks[3+i]);
    end
    bus_stop();
  endtask

  task automatic blk_read(input logic [6:0] a, input logic [7:0] cmd, input int nd,
                          output logic ok, output logic [7:0] cnt);
    logic k0, k1, k2;
    bus_start();
    put_byte({a, 1'b0}, k0);
    put_byte(cmd, k1);
    bus_rstart();
    put_byte({a, 1'b1}, k2);
    ok = k0 & k1 & k2;
    cnt = 8'h00;
    if (ok) begin
      get_byte(1'b1, cnt);
      for (int i = 0; i < nd; i++) get_byte(i < nd - 1, rdat[i]);
    end
    bus_stop();
  endtask

  task automatic do_reset(input logic [1:0] as, input logic [1:0] ms);
    a_sel = as; m_sel = ms; m_sel_q = ms;
    rst_n = 1'b0; wq(4); rst_n = 1'b1; wq(3);
    a_sel = ~as; m_sel = ~ms;
    mdl[0] = 8'h00; mdl[1] = 8'hFF; mdl[2] = 8'h00; mdl[3] = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic ok, ack;
    logic [7:0] cnt;
    logic [15:0] acks;
    logic [6:0] me;
    wq(3);
    check("R8 reset out_en", {28'd0, out_en}, 32'hF);
    check("R9 reset sda_oe", {31'd0, sda_oe}, 32'h0);

    for (int as = 0; as < 4; as++) begin
      for (int ms = 0; ms < 4; ms++) begin
        do_reset(2'(as), 2'(ms));
        me = addr_of(2'(as));
        check("R8 out_en after reset", {28'd0, out_en}, 32'hF);
        blk_read(me, 8'h00, 4, ok, cnt);
        check("R1 R2 own address acked after strap change", {31'd0, ok}, 32'h1);
        check("R7 count byte", {24'd0, cnt}, 32'h4);
        check("R3 mode bits in byte 0", {24'd0, rdat[0]}, {24'd0, mode_bits(2'(ms))});
        check("R8 enable reg reset", {24'd0, rdat[1]}, 32'hFF);
        check("R10 reg2 reset", {24'd0, rdat[2]}, 32'h0);
        check("R10 reg3 reset", {24'd0, rdat[3]}, 32'h0);
        for (int p = 0; p < 3; p++) begin
          bus_start();
          put_byte({addr_of(2'(p)), 1'b0}, ack);
          bus_stop();
          check("R1 address probe", {31'd0, ack}, {31'd0, addr_of(2'(p)) == me});
        end
      end
    end

    do_reset(2'b00, 2'b01);
    me = addr_of(2'b00);

    wdat[0] = 8'hFF; wdat[1] = 8'h5A; wdat[2] = 8'hC3; wdat[3] = 8'h81;
    blk_write(me, 8'h00, 8'd4, 4, acks);
    check("R5 all bytes acked", {16'd0, acks}, 32'h7F);
    mdl[0] = 8'hF5; mdl[1] = 8'h5A; mdl[2] = 8'hC3; mdl[3] = 8'h81;
    check("R8 out_en follows reg", {28'd0, out_en}, 32'hA);
    blk_read(me, 8'h00, 4, ok, cnt);
    check("R4 byte0 ro bits", {24'd0, rdat[0]}, 32'hFD);
    for (int i = 1; i < 4; i++) check("R5 write data", {24'd0, rdat[i]}, {24'd0, view(i)});

    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    blk_write(me, 8'h03, 8'd3, 3, acks);
    check("R5 wrap write acked", {16'd0, acks}, 32'h3F);
    mdl[3] = 8'h11; mdl[0] = 8'h20; mdl[1] = 8'h33;
    check("R8 out_en after wrap", {28'd0, out_en}, 32'h3);
    blk_read(me, 8'h02, 6, ok, cnt);
    for (int i = 0; i < 6; i++) check("R7 wrapped read", {24'd0, rdat[i]}, {24'd0, view((2 + i) % 4)});

    wdat[0] = 8'h44; wdat[1] = 8'h99;
    blk_write(me, 8'h02, 8'd1, 2, acks);
    check("R6 extra byte nacked", {30'd0, acks[4:3]}, 32'h1);
    mdl[2] = 8'h44;
    blk_read(me, 8'h02, 2, ok, cnt);
    check("R6 counted byte written", {24'd0, rdat[0]}, 32'h44);
    check("R6 extra byte not written", {24'd0, rdat[1]}, 32'h11);

    wdat[0] = 8'h77;
    blk_write(me, 8'h01, 8'd0, 1, acks);
    check("R6 zero count nack", {31'd0, acks[3]}, 32'h0);
    blk_read(me, 8'h01, 1, ok, cnt);
    check("R6 zero count no write", {24'd0, rdat[0]}, 32'h33);

    ref_ok = 1'b0; wq(2);
    wdat[0] = 8'h00;
    blk_write(me, 8'h01, 8'd1, 1, acks);
    check("R9 no ack without ref", {31'd0, acks[0]}, 32'h0);
    check("R9 out_en kept", {28'd0, out_en}, 32'h3);
    ref_ok = 1'b1; wq(2);

    begin
      logic k0, k1, k2, k3;
      bus_start();
      put_byte({me, 1'b0}, k0);
      put_byte(8'h01, k1);
      ref_ok = 1'b0;
      put_byte(8'h01, k2);
      put_byte(8'h00, k3);
      bus_stop();
      ref_ok = 1'b1; wq(2);
      check("R9 header acked before drop", {30'd0, k0, k1}, 32'h3);
      check("R9 bytes after drop nacked", {30'd0, k2, k3}, 32'h0);
      check("R9 out_en after drop", {28'd0, out_en}, 32'h3);
    end
    blk_read(me, 8'h01, 1, ok, cnt);
    check("R9 reg1 unchanged", {24'd0, rdat[0]}, 32'h33);
    check("R7 sda released after read", {31'd0, sda_oe}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule